// File: doc/BRIEF.md
# Load-Use Stall and Branch Flush Controller

This block decides, every cycle, whether the front of a five-stage in-order pipeline advances, holds or discards work. It watches the instruction sitting in the fetch/decode register and the control and result bits held in the decode/execute register. When a load in the execute stage writes a register that the decoding instruction reads, the block freezes the program counter and the fetch/decode register for one cycle. In that same cycle it selects all-zero control bits into the decode/execute register, so the execute stage receives a bubble that writes neither a register nor memory. The load itself moves on. In the next cycle the decode/execute register holds the bubble, whose memory-read flag is clear, so the hold drops by itself.

The front end predicts branches not taken. When the branch in the decode/execute register resolves as taken, the block orders the fetch/decode register cleared to an all-zero word, which decodes as a no-op. The decode/execute register carries the branch flag and the comparator's zero flag. A taken branch overrides a load-use hold in the same cycle, because the decoding instruction is then on the wrong path. Unconditional jump encodings in decode never cause a hold, because their register fields only alias an address.

The decisions are combinational on the current inputs. A small state register records the action taken in the previous cycle (run, bubble or squash). The bound checker uses that record to confirm the sequencing.

Top module: `hz_ctrl`

## Requirements
- R1: With the execute-stage memory-read flag at 1 and the execute-stage destination equal to the decode instruction's first source field (bits 25:21), the block stalls: `pc_we`=0, `ifid_we`=0, `ctrl_zero`=1, `ifid_flush`=0.
- R2: With the memory-read flag at 1 and the destination equal to the decode instruction's second source field (bits 20:16), the block stalls in the same way as in R1.
- R3: In a stall, the program counter enable and the fetch/decode enable are both 0, so the fetch and decode stages hold their contents.
- R4: In a stall, `ctrl_zero` is 1, selecting all-zero control bits into the decode/execute register.
- R5: With the memory-read flag at 0, or with a destination that matches neither source field, and with no taken branch, the block runs: `pc_we`=1, `ifid_we`=1, `ctrl_zero`=0, `ifid_flush`=0.
- R6: A decode opcode (bits 31:26) of 000010 or 000011 (jump, jump-and-link) masks the load-use comparison, and the block runs.
- R7: With the branch flag and the zero flag both at 1, the block flushes: `ifid_flush`=1, `pc_we`=1, `ifid_we`=1, `ctrl_zero`=0.
- R8: A branch flag of 1 with the zero flag at 0 (branch not taken) causes no flush.
- R9: When a stall condition and a taken branch occur together, the flush outputs of R7 apply and no stall is raised.
- R10: The hold lasts only while the condition is present. When the decode/execute register then holds the bubble (memory-read flag 0), the block runs in that cycle, so a load costs exactly one stall cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the action record |
| rst_n | input | 1 | Active-low asynchronous reset of the action record |
| ifid_instr | input | 32 | Instruction in the fetch/decode register |
| idex_mem_read | input | 1 | Memory-read flag of the execute-stage instruction |
| idex_rt | input | 5 | Destination field of the execute-stage instruction |
| idex_branch | input | 1 | Branch flag in the decode/execute register |
| idex_zero | input | 1 | Zero (equal) result for that branch |
| pc_we | output | 1 | Program counter write enable |
| ifid_we | output | 1 | Fetch/decode register write enable |
| ctrl_zero | output | 1 | Select all-zero control bits into decode/execute |
| ifid_flush | output | 1 | Clear the fetch/decode register to zero |

## Verification
The load-use hold and the taken-branch flush can fall in the same cycle. This happens when a load's destination matches a decoding source field while a resolved, equal branch sits in the decode/execute register. The bench provokes it by driving a matching load, the branch flag and the zero flag at once. It judges the result by the flush outputs alone being active, with both enables high and the bubble select low. A separate sequence lets the load move on into a bubble and confirms that the hold ends after a single cycle.

// File: rtl/hz_pkg.sv
package hz_pkg;

    typedef enum logic [1:0] {
        ACT_RUN   = 2'd0,
        ACT_STALL = 2'd1,
        ACT_FLUSH = 2'd2
    } hz_action_t;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_BUBBLE = 2'd1,
        ST_SQUASH = 2'd2
    } hz_state_t;

endpackage

// File: rtl/hz_loaduse_detect.sv
module hz_loaduse_detect #(
    parameter int INSTR_W = 32,
    parameter int REG_AW  = 5,
    parameter int OPC_W   = 6,
    parameter logic [OPC_W-1:0] OPC_J   = 6'b000010,
    parameter logic [OPC_W-1:0] OPC_JAL = 6'b000011
) (
    input  logic [INSTR_W-1:0] instr,
    input  logic               mem_read,
    input  logic [REG_AW-1:0]  ld_dst,
    output logic               hazard
);
    localparam int OPC_LSB = INSTR_W - OPC_W;
    localparam int RS_LSB  = OPC_LSB - REG_AW;
    localparam int RT_LSB  = RS_LSB - REG_AW;
    localparam int NSRC    = 2;

    logic [OPC_W-1:0] opcode;
    logic [NSRC-1:0]  src_hit;
    logic             is_jump;

    assign opcode = instr[INSTR_W-1:OPC_LSB];

    genvar g;
    generate
        for (g = 0; g < NSRC; g++) begin : g_src
            localparam int LSB = (g == 0) ? RS_LSB : RT_LSB;
            assign src_hit[g] = (instr[LSB +: REG_AW] == ld_dst);
        end
    endgenerate

    always_comb begin
        is_jump = (opcode == OPC_J) || (opcode == OPC_JAL);
        hazard  = mem_read && (|src_hit) && !is_jump;
    end
endmodule

// File: rtl/hz_branch_resolve.sv
module hz_branch_resolve (
    input  logic branch,
    input  logic zero,
    output logic taken
);
    always_comb begin
        taken = branch && zero;
    end
endmodule

// File: rtl/hz_arbiter.sv
module hz_arbiter
    import hz_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stall_req,
    input  logic       flush_req,
    output logic       pc_we,
    output logic       ifid_we,
    output logic       ctrl_zero,
    output logic       ifid_flush,
    output hz_state_t  state_q
);
    hz_action_t act;
    hz_state_t  state_d;

    always_comb begin
        if (flush_req)      act = ACT_FLUSH;
        else if (stall_req) act = ACT_STALL;
        else                act = ACT_RUN;
    end

    always_comb begin
        unique case (act)
            ACT_RUN:   state_d = ST_RUN;
            ACT_STALL: state_d = ST_BUBBLE;
            ACT_FLUSH: state_d = ST_SQUASH;
            default:   state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        pc_we      = 1'b1;
        ifid_we    = 1'b1;
        ctrl_zero  = 1'b0;
        ifid_flush = 1'b0;
        unique case (act)
            ACT_RUN: begin
            end
            ACT_STALL: begin
                pc_we     = 1'b0;
                ifid_we   = 1'b0;
                ctrl_zero = 1'b1;
            end
            ACT_FLUSH: begin
                ifid_flush = 1'b1;
            end
            default: begin
            end
        endcase
    end
endmodule

// File: rtl/hz_ctrl.sv
module hz_ctrl
    import hz_pkg::*;
#(
    parameter int INSTR_W = 32,
    parameter int REG_AW  = 5,
    parameter int OPC_W   = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INSTR_W-1:0] ifid_instr,
    input  logic               idex_mem_read,
    input  logic [REG_AW-1:0]  idex_rt,
    input  logic               idex_branch,
    input  logic               idex_zero,
    output logic               pc_we,
    output logic               ifid_we,
    output logic               ctrl_zero,
    output logic               ifid_flush
);
    logic      stall_req;
    logic      flush_req;
    hz_state_t state_q;

    hz_loaduse_detect #(
        .INSTR_W (INSTR_W),
        .REG_AW  (REG_AW),
        .OPC_W   (OPC_W)
    ) u_lu (
        .instr    (ifid_instr),
        .mem_read (idex_mem_read),
        .ld_dst   (idex_rt),
        .hazard   (stall_req)
    );

    hz_branch_resolve u_br (
        .branch (idex_branch),
        .zero   (idex_zero),
        .taken  (flush_req)
    );

    hz_arbiter u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .stall_req  (stall_req),
        .flush_req  (flush_req),
        .pc_we      (pc_we),
        .ifid_we    (ifid_we),
        .ctrl_zero  (ctrl_zero),
        .ifid_flush (ifid_flush),
        .state_q    (state_q)
    );
endmodule

// File: rtl/hz_ctrl_chk.sv
module hz_ctrl_chk
    import hz_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] ifid_instr,
    input logic        idex_mem_read,
    input logic [4:0]  idex_rt,
    input logic        idex_branch,
    input logic        idex_zero,
    input logic        pc_we,
    input logic        ifid_we,
    input logic        ctrl_zero,
    input logic        ifid_flush,
    input hz_state_t   state_q
);
    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_zero |-> (!pc_we && !ifid_we)); // R3

    AST_RS_MATCH_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (idex_mem_read && idex_rt == ifid_instr[25:21] && ifid_instr[31:27] != 5'b00001
         && !(idex_branch && idex_zero)) |-> ctrl_zero); // R1

    AST_JUMP_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (ifid_instr[31:27] == 5'b00001) |-> !ctrl_zero); // R6

    AST_TAKEN_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (idex_branch && idex_zero) |-> (ifid_flush && pc_we && ifid_we)); // R7

    AST_FLUSH_OVER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ctrl_zero, ifid_flush})); // R9

    AST_NOT_TAKEN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !idex_zero |-> !ifid_flush); // R8

    AST_BUBBLE_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_zero |=> (state_q == ST_BUBBLE)); // R10
endmodule

bind hz_ctrl hz_ctrl_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ifid_instr    (ifid_instr),
    .idex_mem_read (idex_mem_read),
    .idex_rt       (idex_rt),
    .idex_branch   (idex_branch),
    .idex_zero     (idex_zero),
    .pc_we         (pc_we),
    .ifid_we       (ifid_we),
    .ctrl_zero     (ctrl_zero),
    .ifid_flush    (ifid_flush),
    .state_q       (state_q)
);

// File: tb/hz_ctrl_tb.sv
`timescale 1ns/1ps
module hz_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ifid_instr = '0;
    logic        idex_mem_read = 1'b0;
    logic [4:0]  idex_rt = '0;
    logic        idex_branch = 1'b0;
    logic        idex_zero = 1'b0;
    logic        pc_we, ifid_we, ctrl_zero, ifid_flush;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    hz_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .ifid_instr(ifid_instr),
        .idex_mem_read(idex_mem_read), .idex_rt(idex_rt),
        .idex_branch(idex_branch), .idex_zero(idex_zero),
        .pc_we(pc_we), .ifid_we(ifid_we), .ctrl_zero(ctrl_zero),
        .ifid_flush(ifid_flush)
    );

    function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] rs,
                                       input logic [4:0] rt);
        return {op, rs, rt, 16'h1820};
    endfunction

    // expected {pc_we, ifid_we, ctrl_zero, ifid_flush}
    task automatic expect_out(input string req, input logic [3:0] exp);
        logic [3:0] act;
        act = {pc_we, ifid_we, ctrl_zero, ifid_flush};
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    localparam logic [3:0] RUN   = 4'b1100;
    localparam logic [3:0] STALL = 4'b0010;
    localparam logic [3:0] FLUSH = 4'b1101;

    task automatic apply(input logic [31:0] ins, input logic mr, input logic [4:0] rt,
                         input logic br, input logic zf);
        @(negedge clk);
        ifid_instr = ins; idex_mem_read = mr; idex_rt = rt;
        idex_branch = br; idex_zero = zf;
        #1;
    endtask

    task automatic t_reset;
        apply('0, 1'b0, 5'd0, 1'b0, 1'b0);
        expect_out("R5 reset idle", RUN);
    endtask

    task automatic t_rs_stall;
        apply(mk(6'b000000, 5'd7, 5'd9), 1'b1, 5'd7, 1'b0, 1'b0);
        expect_out("R1 rs match", STALL);
        expect_out("R3 enables low", STALL);
    endtask

    task automatic t_rt_stall;
        apply(mk(6'b000000, 5'd3, 5'd12), 1'b1, 5'd12, 1'b0, 1'b0);
        expect_out("R2 rt match", STALL);
        expect_out("R4 bubble select", STALL);
    endtask

    task automatic t_no_hazard;
        apply(mk(6'b000000, 5'd7, 5'd9), 1'b0, 5'd7, 1'b0, 1'b0);
        expect_out("R5 no mem read", RUN);
        apply(mk(6'b100011, 5'd1, 5'd2), 1'b1, 5'd5, 1'b0, 1'b0);
        expect_out("R5 no match", RUN);
    endtask

    task automatic t_jump;
        apply(mk(6'b000010, 5'd4, 5'd4), 1'b1, 5'd4, 1'b0, 1'b0);
        expect_out("R6 j masked", RUN);
        apply(mk(6'b000011, 5'd8, 5'd4), 1'b1, 5'd8, 1'b0, 1'b0);
        expect_out("R6 jal masked", RUN);
        apply(mk(6'b000100, 5'd8, 5'd4), 1'b1, 5'd8, 1'b0, 1'b0);
        expect_out("R6 beq not masked", STALL);
    endtask

    task automatic t_branch;
        apply(mk(6'b000000, 5'd1, 5'd2), 1'b0, 5'd0, 1'b1, 1'b1);
        expect_out("R7 taken flush", FLUSH);
        apply(mk(6'b000000, 5'd1, 5'd2), 1'b0, 5'd0, 1'b1, 1'b0);
        expect_out("R8 not taken", RUN);
        apply(mk(6'b000000, 5'd1, 5'd2), 1'b0, 5'd0, 1'b0, 1'b1);
        expect_out("R8 zero without branch", RUN);
    endtask

    task automatic t_both;
        apply(mk(6'b000000, 5'd6, 5'd2), 1'b1, 5'd6, 1'b1, 1'b1);
        expect_out("R9 flush beats stall", FLUSH);
    endtask

    task automatic t_one_cycle;
        apply(mk(6'b000000, 5'd10, 5'd11), 1'b1, 5'd10, 1'b0, 1'b0);
        expect_out("R10 stall cycle", STALL);
        apply(mk(6'b000000, 5'd10, 5'd11), 1'b0, 5'd0, 1'b0, 1'b0);
        expect_out("R10 bubble next cycle runs", RUN);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_rs_stall();
        t_rt_stall();
        t_no_hazard();
        t_jump();
        t_branch();
        t_both();
        t_one_cycle();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule